// File: doc/BRIEF.md
# ROM Parity Scan Checker

This block certifies a read-only memory without knowing what was programmed into it. Every stored word carries one extra parity bit beside its data bits. A start pulse sends an internal counter through the whole address range, one address per cycle. The block checks each returned word, parity bit included, against an even or an odd rule. The rule is chosen by a configuration input and held for the whole scan.

The memory answers one cycle after an address is presented, so the parity check runs one stage behind the address counter. At the end of the scan the block raises a one-cycle done strobe. It gives a single verdict, pass or fail, and keeps it until the next scan starts. It also reports the address of the first word that broke the rule and a saturating count of broken words. Nothing about the stored data is needed beyond the parity convention.

Top module: `rom_parity_scan`

## Requirements
- R1: With the even rule selected (`odd_mode_i` = 0 when the scan is accepted), a word passes exactly when the number of ones across all DATA_W+1 bits of `rom_word_i` is even.
- R2: With the odd rule selected (`odd_mode_i` = 1 when the scan is accepted), a word passes exactly when that number of ones is odd.
- R3: After a start is accepted, `rom_en_o` is high for exactly 2**ADDR_W consecutive cycles, and `rom_addr_o` presents 0, 1, ..., 2**ADDR_W-1 in ascending order during those cycles.
- R4: The word checked for an address is the value on `rom_word_i` in the cycle after that address was presented with `rom_en_o` high.
- R5: `done_o` is high for exactly one cycle. That cycle begins at the (2**ADDR_W+1)-th rising edge after the edge that accepted the start.
- R6: From the done cycle until the next accepted start, exactly one of `pass_o` and `fail_o` is high, and `fail_o` is high exactly when at least one word broke the rule. While `busy_o` is high, both are low.
- R7: When the scan fails, `first_fail_addr_o` holds the lowest address whose word broke the rule. Later failures do not change it.
- R8: `err_count_o` equals the number of words that broke the rule, saturating at 2**CNT_W-1. It is cleared when a start is accepted.
- R9: A start pulse while `busy_o` is high is ignored: the sweep continues without restarting, and only one done strobe follows.
- R10: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o`, `rom_en_o` and `err_count_o` are all zero.
- R11: The parity rule is sampled when a start is accepted. Changes on `odd_mode_i` during a scan have no effect on that scan's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a scan when the block is idle |
| odd_mode_i | input | 1 | Parity rule: 0 even, 1 odd; sampled at start |
| rom_en_o | output | 1 | Read enable toward the memory |
| rom_addr_o | output | ADDR_W | Read address toward the memory |
| rom_word_i | input | DATA_W+1 | Word returned by the memory one cycle after the address, parity bit included |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan strobe |
| pass_o | output | 1 | Every word obeyed the rule |
| fail_o | output | 1 | At least one word broke the rule |
| first_fail_addr_o | output | ADDR_W | Lowest failing address of the last scan |
| err_count_o | output | CNT_W | Saturating count of failing words |

## Verification
The bench builds the block with ADDR_W = 5 and CNT_W = 3. A full 32-word sweep then takes a few dozen cycles, so many whole scans fit in one run, and the exact done latency can be checked cycle by cycle. The 3-bit counter puts saturation at 7, and ordinary fault patterns reach it, including a memory where every word fails. PAR_STYLE = 1 selects the chained parity evaluator; the default selects the reduction form.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_SWEEP = 2'd1,
      SC_DRAIN = 2'd2
   } scan_state_e;

   // A word is good when the parity of its ones matches the selected rule.
   function automatic logic word_good(input logic ones_odd, input logic odd_rule);
      return ones_odd == odd_rule;
   endfunction

endpackage

// File: rtl/rps_addr_gen.sv
module rps_addr_gen
   import rps_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              odd_mode_i,
   input  logic              finish_i,
   output logic              accept_o,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              at_last_o,
   output logic              rule_odd_o,
   output scan_state_e       state_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   scan_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rule_q;

   assign accept_o   = start_i && (state_q == SC_IDLE);
   assign rd_en_o    = (state_q == SC_SWEEP);
   assign at_last_o  = (addr_q == LAST_ADDR);
   assign addr_o     = addr_q;
   assign rule_odd_o = rule_q;
   assign state_o    = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         addr_q  <= '0;
         rule_q  <= 1'b0;
      end else begin
         unique case (state_q)
            SC_IDLE: begin
               if (start_i) begin
                  state_q <= SC_SWEEP;
                  addr_q  <= '0;
                  rule_q  <= odd_mode_i;
               end
            end
            SC_SWEEP: begin
               if (addr_q == LAST_ADDR) begin
                  state_q <= SC_DRAIN;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            SC_DRAIN: begin
               if (finish_i) begin
                  state_q <= SC_IDLE;
               end
            end
            default: state_q <= SC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rps_parity_eval.sv
module rps_parity_eval #(
   parameter int WORD_W    = 9,
   parameter int PAR_STYLE = 0
) (
   input  logic [WORD_W-1:0] word_i,
   output logic              ones_odd_o
);

   generate
      if (PAR_STYLE == 0) begin : g_reduce
         assign ones_odd_o = ^word_i;
      end else begin : g_chain
         logic [WORD_W-1:0] acc;
         assign acc[0] = word_i[0];
         for (genvar i = 1; i < WORD_W; i++) begin : g_link
            assign acc[i] = acc[i-1] ^ word_i[i];
         end
         assign ones_odd_o = acc[WORD_W-1];
      end
   endgenerate

endmodule

// File: rtl/rps_err_track.sv
module rps_err_track #(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              bad_i,
   input  logic [ADDR_W-1:0] tag_i,
   output logic              any_o,
   output logic              any_next_o,
   output logic [ADDR_W-1:0] first_addr_o,
   output logic [CNT_W-1:0]  count_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic              any_q;
   logic [ADDR_W-1:0] first_q;
   logic [CNT_W-1:0]  cnt_q;

   assign any_o        = any_q;
   assign any_next_o   = any_q || bad_i;
   assign first_addr_o = first_q;
   assign count_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_q   <= 1'b0;
         first_q <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         any_q   <= 1'b0;
         first_q <= '0;
         cnt_q   <= '0;
      end else if (bad_i) begin
         any_q <= 1'b1;
         if (!any_q) begin
            first_q <= tag_i;
         end
         if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rom_parity_scan.sv
module rom_parity_scan
   import rps_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 10,
   parameter int CNT_W     = 8,
   parameter int PAR_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              odd_mode_i,
   output logic              rom_en_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   input  logic [DATA_W:0]   rom_word_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [ADDR_W-1:0] first_fail_addr_o,
   output logic [CNT_W-1:0]  err_count_o
);

   localparam int WORD_W = DATA_W + 1;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("rom_parity_scan: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
         $error("rom_parity_scan: ADDR_W must lie in 1..30");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("rom_parity_scan: CNT_W must be at least 1");
      end
      if (PAR_STYLE < 0 || PAR_STYLE > 1) begin : g_bad_style
         $error("rom_parity_scan: PAR_STYLE must be 0 or 1");
      end
   endgenerate

   scan_state_e       state;
   logic              accept;
   logic              at_last;
   logic              rule_odd;
   logic              finish;
   logic              ones_odd;
   logic              word_bad;
   logic              any_fail;
   logic              any_next;

   // Read-latency stage: tracks which address the returning word belongs to
   logic              vld_q;
   logic              last_q;
   logic [ADDR_W-1:0] tag_q;

   logic              done_q;
   logic              pass_q;
   logic              fail_q;

   rps_addr_gen #(
      .ADDR_W (ADDR_W)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .odd_mode_i (odd_mode_i),
      .finish_i   (finish),
      .accept_o   (accept),
      .rd_en_o    (rom_en_o),
      .addr_o     (rom_addr_o),
      .at_last_o  (at_last),
      .rule_odd_o (rule_odd),
      .state_o    (state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         vld_q  <= rom_en_o;
         last_q <= rom_en_o && at_last;
         tag_q  <= rom_addr_o;
      end
   end

   rps_parity_eval #(
      .WORD_W    (WORD_W),
      .PAR_STYLE (PAR_STYLE)
   ) u_par (
      .word_i     (rom_word_i),
      .ones_odd_o (ones_odd)
   );

   assign word_bad = vld_q && !word_good(ones_odd, rule_odd);
   assign finish   = vld_q && last_q;

   rps_err_track #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_err (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (accept),
      .bad_i        (word_bad),
      .tag_i        (tag_q),
      .any_o        (any_fail),
      .any_next_o   (any_next),
      .first_addr_o (first_fail_addr_o),
      .count_o      (err_count_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
         end else if (finish) begin
            pass_q <= !any_next;
            fail_q <= any_next;
         end
      end
   end

   assign busy_o = (state != SC_IDLE);
   assign done_o = done_q;
   assign pass_o = pass_q;
   assign fail_o = fail_q;

endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rom_en_o,
   input logic [ADDR_W-1:0] rom_addr_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              pass_o,
   input logic              fail_o,
   input logic [ADDR_W-1:0] first_fail_addr_o,
   input logic [CNT_W-1:0]  err_count_o
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

   AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_en_o && $past(rom_en_o)) |-> (rom_addr_o == ADDR_W'($past(rom_addr_o) + 1'b1))); // R3

   AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_en_o && !$past(rom_en_o)) |-> (rom_addr_o == '0)); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R5

   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o)); // R6

   AST_VERDICT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o || fail_o)); // R6

   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!pass_o && !fail_o)); // R6

   AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && ($past(err_count_o) != '0)) |-> $stable(first_fail_addr_o)); // R7

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (err_count_o >= $past(err_count_o))); // R8

   AST_FAIL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fail_o) |-> (err_count_o != '0)); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && rom_en_o && (rom_addr_o != TOP_ADDR))
      |=> (rom_en_o && (rom_addr_o == ADDR_W'($past(rom_addr_o) + 1'b1)))); // R9

endmodule

bind rom_parity_scan rps_checker #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_rps_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .start_i           (start_i),
   .rom_en_o          (rom_en_o),
   .rom_addr_o        (rom_addr_o),
   .busy_o            (busy_o),
   .done_o            (done_o),
   .pass_o            (pass_o),
   .fail_o            (fail_o),
   .first_fail_addr_o (first_fail_addr_o),
   .err_count_o       (err_count_o)
);

// File: tb/tb_rom_parity_scan.sv
module tb_rom_parity_scan;

   localparam int DATA_W = 8;
   localparam int ADDR_W = 5;
   localparam int CNT_W  = 3;
   localparam int DEPTH  = 2 ** ADDR_W;
   localparam int SAT    = 2 ** CNT_W - 1;

   // vector fields: scan_odd[17] fill_odd[16] first[15:11] stride[10:6] nbad[5:0]
   localparam int NVEC = 9;
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 5'd0,  5'd1, 6'd0},
      {1'b1, 1'b1, 5'd0,  5'd1, 6'd0},
      {1'b0, 1'b0, 5'd0,  5'd1, 6'd1},
      {1'b1, 1'b1, 5'd31, 5'd1, 6'd1},
      {1'b0, 1'b0, 5'd5,  5'd4, 6'd3},
      {1'b1, 1'b1, 5'd2,  5'd3, 6'd10},
      {1'b0, 1'b0, 5'd0,  5'd1, 6'd32},
      {1'b1, 1'b0, 5'd0,  5'd1, 6'd0},
      {1'b0, 1'b1, 5'd4,  5'd1, 6'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              odd_mode_i = 1'b0;
   logic              rom_en_o;
   logic [ADDR_W-1:0] rom_addr_o;
   logic [DATA_W:0]   rom_word_i;
   logic              busy_o;
   logic              done_o;
   logic              pass_o;
   logic              fail_o;
   logic [ADDR_W-1:0] first_fail_addr_o;
   logic [CNT_W-1:0]  err_count_o;

   logic [DATA_W:0] mem [DEPTH];

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (rom_en_o) rom_word_i <= mem[rom_addr_o];
   end

   rom_parity_scan #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .PAR_STYLE (1)
   ) dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .start_i           (start_i),
      .odd_mode_i        (odd_mode_i),
      .rom_en_o          (rom_en_o),
      .rom_addr_o        (rom_addr_o),
      .rom_word_i        (rom_word_i),
      .busy_o            (busy_o),
      .done_o            (done_o),
      .pass_o            (pass_o),
      .fail_o            (fail_o),
      .first_fail_addr_o (first_fail_addr_o),
      .err_count_o       (err_count_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Build memory: every word obeys fill_odd, then marked words get a flipped parity bit
   task automatic fill(input logic fill_odd, input int first, input int stride,
                       input int nbad, input int seed);
      for (int a = 0; a < DEPTH; a++) begin
         logic [DATA_W-1:0] d;
         d = DATA_W'(a * 37 + seed);
         mem[a] = {(^d) ^ fill_odd, d};
      end
      for (int i = 0; i < nbad; i++) begin
         int idx;
         idx = first + i * stride;
         if (idx < DEPTH) mem[idx][DATA_W] = ~mem[idx][DATA_W];
      end
   endtask

   // Runs one scan and checks every result against the memory contents
   task automatic scan_and_check(input logic scan_odd, input bit extra_start,
                                 input bit toggle_mode, input string tag);
      int  n, sweep_cnt, exp_cnt, exp_first, lat;
      bit  got, order_ok, quiet_ok;
      n = 0; sweep_cnt = 0; got = 0; order_ok = 1; quiet_ok = 1; lat = -1;
      exp_cnt = 0; exp_first = -1;
      for (int a = 0; a < DEPTH; a++) begin
         if ((^mem[a]) != scan_odd) begin   // R1 R2: rule on ones of all bits
            exp_cnt++;
            if (exp_first < 0) exp_first = a;
         end
      end
      @(negedge clk);
      odd_mode_i = scan_odd;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (rom_en_o) begin
         if (rom_addr_o != ADDR_W'(sweep_cnt)) order_ok = 0;
         sweep_cnt++;
      end
      while (!got && n < DEPTH + 20) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start_i = extra_start && (n == 5);
         if (toggle_mode && n == 3) odd_mode_i = ~scan_odd;
         if (busy_o && (pass_o || fail_o)) quiet_ok = 0;
         if (rom_en_o) begin
            if (rom_addr_o != ADDR_W'(sweep_cnt)) order_ok = 0;
            sweep_cnt++;
         end
         if (done_o) begin
            got = 1;
            lat = n;
         end
      end
      start_i = 1'b0;
      chk(lat == DEPTH + 1, "R5", {tag, " done latency"}, lat, DEPTH + 1);
      chk(sweep_cnt == DEPTH && order_ok, "R3", {tag, " sweep reads"}, sweep_cnt, DEPTH);
      chk(quiet_ok, "R6", {tag, " verdict low while busy"}, !quiet_ok, 0);
      chk(fail_o == (exp_cnt != 0) && pass_o == (exp_cnt == 0), "R6",
          {tag, " fail verdict"}, fail_o, exp_cnt != 0);
      if (exp_cnt != 0)   // R4 R7: tag must follow the read latency
         chk(first_fail_addr_o == ADDR_W'(exp_first), "R7", {tag, " first fail"},
             first_fail_addr_o, exp_first);
      chk(err_count_o == CNT_W'(exp_cnt > SAT ? SAT : exp_cnt), "R8", {tag, " err count"},
          err_count_o, exp_cnt > SAT ? SAT : exp_cnt);
      @(posedge clk);
      @(negedge clk);
      chk(!done_o, "R5", {tag, " done one cycle"}, done_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk(!busy_o && !done_o && !pass_o && !fail_o && !rom_en_o && err_count_o == 0,
          "R10", "reset outputs", {busy_o, done_o, pass_o, fail_o, rom_en_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rom_en_o, "R10", "idle after reset", busy_o, 0);

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         fill(VEC[v][16], int'(VEC[v][15:11]), int'(VEC[v][10:6]), int'(VEC[v][5:0]), v * 11);
         scan_and_check(VEC[v][17], 1'b0, 1'b0, $sformatf("vec%0d", v));
      end

      // R6 verdict held until the next start
      fill(1'b0, 7, 1, 1, 3);
      scan_and_check(1'b0, 1'b0, 1'b0, "hold");
      repeat (5) @(negedge clk);
      chk(fail_o && !pass_o && first_fail_addr_o == 7, "R6", "verdict held", fail_o, 1);

      // R9 start during busy is ignored (latency and single sweep unchanged)
      fill(1'b1, 9, 2, 4, 5);
      scan_and_check(1'b1, 1'b1, 1'b0, "restart_ignored_R9");
      repeat (4) @(negedge clk);
      chk(!busy_o && !done_o, "R9", "no second scan", busy_o, 0);

      // R11 rule change mid-scan has no effect
      fill(1'b0, 0, 1, 0, 9);
      scan_and_check(1'b0, 1'b0, 1'b1, "mode_toggle_R11");
      chk(pass_o, "R11", "pass with sampled rule", pass_o, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule